// File: doc/BRIEF.md
# Event Counter Bank with Per-Counter Event Selection

The block holds ten event counters that a processor core uses to measure its own activity. Counter 0 counts clock cycles and counter 1 counts retired instructions. Counters 2 to 9 are programmable, and each takes one of 256 event inputs through an 8-bit select field. A counter advances only in cycles where three conditions hold: it is enabled, its event is present, and the current privilege level is one that the counter is set to count in.

Software reaches the block through a single-cycle register port. Writes take effect at the clock edge and reads are combinational. Through this port software sets the enables, the privilege qualifiers and the event selects, and it reads and writes the counter values. A status word records the counters whose trigger bit was crossed while their interrupt enable was set. One interrupt output is gated by a global delivery mode and an active flag. Software clears that flag by writing the control word.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every counter reads zero, both control words and the status word read zero, the delivery mode is off and `irq_o` is low.
- R2: A counter increments by exactly one in a cycle when three conditions hold: its count enable is set, its event is high, and its qualifier for the current privilege is set. The user qualifier applies when `kernel_i`=0 and the kernel qualifier when `kernel_i`=1. Otherwise the counter holds its value.
- R3: Counter 0 treats every cycle as an event, and counter 1 uses `inst_ret_i` as its event. Neither counter has a select field.
- R4: Select word 0 (address 2) holds the codes for counters 2..5, and select word 1 (address 3) holds those for counters 6..9. Counter i uses byte (i-2) of word 0 or byte (i-6) of word 1, at bit offset 8×byte.
- R5: Control word 0 (address 0) is laid out as follows: count enables for counters 0..7 in bits [7:0] and for counters 8..9 in bits [17:16]; interrupt enables for counters 0..7 in bits [15:8] and for counters 8..9 in bits [19:18]; delivery mode in bit 20 (0 off, 1 fast); active flag in bit 21, which is read-only. Control word 1 (address 1) holds the user qualifiers in bits [7:0] and [17:16] and the kernel qualifiers in bits [15:8] and [19:18], with the same grouping.
- R6: Counter i is read and written at address 8+i. It is CNT_W (48) bits wide. Write bits above that width are ignored, reads are zero-extended to 64 bits, and the value wraps from all-ones to zero.
- R7: A write to a counter in the same cycle as a qualifying event loads the written value, and the increment is lost.
- R8: Status bit i (address 4) is set when an increment moves counter i's bit CNT_W-1 from 0 to 1 while interrupt enable i is set. Writing 1 to a status bit clears it. A new set in the same cycle as the clear wins.
- R9: The active flag is set whenever a status bit is newly set. Any other write to control word 0 clears it. `irq_o` is high when the mode is fast, the flag is set and at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Combinational read data for reg_addr_i |
| event_i | input | 256 | Event inputs for programmable counters |
| inst_ret_i | input | 1 | Instruction retired this cycle |
| kernel_i | input | 1 | Current privilege: 1 kernel, 0 user |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong select offset or enable grouping shows up on the first readback after a burst of events: the wrong counter moves, or none does. A lost or duplicated increment shifts the count by one on the next read. A fault in trigger detection or status gating shows up as a wrong status word, or a wrong `irq_o` level, in the cycle right after the crossing edge. A fault in clearing the active flag shows up as an `irq_o` that stays high after the control write that should have dropped it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned NUM_CNT  = 10;
  localparam int unsigned NUM_PROG = NUM_CNT - 2;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned WORD_W   = 32;

  localparam logic [ADDR_W-1:0] A_CTRL0 = 5'd0;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 5'd1;
  localparam logic [ADDR_W-1:0] A_SEL0  = 5'd2;
  localparam logic [ADDR_W-1:0] A_SEL1  = 5'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'd4;
  localparam int unsigned       CNT_BASE = 8;

  // control word 0 / 1 field positions
  localparam int unsigned LO_A   = 0;
  localparam int unsigned LO_B   = 8;
  localparam int unsigned HI_A   = 16;
  localparam int unsigned HI_B   = 18;
  localparam int unsigned MODE_B = 20;
  localparam int unsigned ACT_B  = 21;

  typedef enum logic {IMODE_OFF = 1'b0, IMODE_FAST = 1'b1} imode_e;

  typedef struct packed {
    logic [NUM_CNT-1:0] cnt_en;
    logic [NUM_CNT-1:0] irq_en;
    logic [NUM_CNT-1:0] usr_en;
    logic [NUM_CNT-1:0] krn_en;
    imode_e             mode;
  } cfg_t;
endpackage

// File: rtl/pmc_cfg.sv
module pmc_cfg
  import pmc_pkg::*;
#(
  parameter int unsigned SEL_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [WORD_W-1:0]              wdata_i,
  output cfg_t                           cfg_o,
  output logic [NUM_PROG-1:0][SEL_W-1:0] sel_o,
  output logic                           ctrl0_wr_o
);
  localparam int unsigned PER_WORD = NUM_PROG / 2;

  cfg_t                           cfg_q;
  logic [NUM_PROG-1:0][SEL_W-1:0] sel_q;
  logic                           wr0, wr1, wrs0, wrs1;

  assign wr0  = we_i && (addr_i == A_CTRL0);
  assign wr1  = we_i && (addr_i == A_CTRL1);
  assign wrs0 = we_i && (addr_i == A_SEL0);
  assign wrs1 = we_i && (addr_i == A_SEL1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (wr0) begin
        cfg_q.cnt_en <= {wdata_i[HI_A+:2], wdata_i[LO_A+:8]};
        cfg_q.irq_en <= {wdata_i[HI_B+:2], wdata_i[LO_B+:8]};
        cfg_q.mode   <= imode_e'(wdata_i[MODE_B]);
      end
      if (wr1) begin
        cfg_q.usr_en <= {wdata_i[HI_A+:2], wdata_i[LO_A+:8]};
        cfg_q.krn_en <= {wdata_i[HI_B+:2], wdata_i[LO_B+:8]};
      end
    end
  end

  for (genvar j = 0; j < PER_WORD; j++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[j]          <= '0;
        sel_q[j+PER_WORD] <= '0;
      end else begin
        if (wrs0) sel_q[j]          <= wdata_i[j*SEL_W+:SEL_W];
        if (wrs1) sel_q[j+PER_WORD] <= wdata_i[j*SEL_W+:SEL_W];
      end
    end
  end

  assign cfg_o      = cfg_q;
  assign sel_o      = sel_q;
  assign ctrl0_wr_o = wr0;

  assert_ctrl0_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> (cfg_q.cnt_en == $past({wdata_i[HI_A+:2], wdata_i[LO_A+:8]})));
  assert_ctrl1_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr1 |=> (cfg_q.krn_en == $past({wdata_i[HI_B+:2], wdata_i[LO_B+:8]})));
endmodule

// File: rtl/pmc_ctr.sv
module pmc_ctr #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] val_o,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam int unsigned      TRIG = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_nxt;
  end

  // trigger bit rising because of an increment, not a write
  assign trip_o = inc_i && !wr_i && !cnt_q[TRIG] && cnt_nxt[TRIG];
  assign val_o  = cnt_q;

  assert_write_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && inc_i) |=> (cnt_q == $past(cnt_q) + ONE));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmc_irq.sv
module pmc_irq
  import pmc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] trip_i,
  input  logic [NUM_CNT-1:0] irq_en_i,
  input  logic               stat_wr_i,
  input  logic [NUM_CNT-1:0] stat_clr_i,
  input  logic               ctrl0_wr_i,
  input  imode_e             mode_i,
  output logic [NUM_CNT-1:0] status_o,
  output logic               active_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] status_q, new_w, clr_w;
  logic               active_q;

  assign new_w = trip_i & irq_en_i;
  assign clr_w = stat_wr_i ? stat_clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      active_q <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_w) | new_w;
      if (|new_w)          active_q <= 1'b1;
      else if (ctrl0_wr_i) active_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign active_o = active_q;
  assign irq_o    = (mode_i == IMODE_FAST) && active_q && (|status_q);

  assert_stat_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|new_w) |=> ((status_q & $past(new_w)) == $past(new_w)));
  assert_active_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|new_w) |=> active_q);
  assert_active_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl0_wr_i && !(|new_w)) |=> !active_q);
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned EVT_N = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [EVT_N-1:0]  event_i,
  input  logic              inst_ret_i,
  input  logic              kernel_i,
  output logic              irq_o
);
  localparam int unsigned SEL_W    = $clog2(EVT_N);
  localparam int unsigned PER_WORD = NUM_PROG / 2;

  cfg_t                           cfg;
  logic [NUM_PROG-1:0][SEL_W-1:0] sel;
  logic                           ctrl0_wr;
  logic [NUM_CNT-1:0]             inc_w, trip_w, cnt_wr, status;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val;
  logic                           active;
  logic                           unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  pmc_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i[WORD_W-1:0]),
    .cfg_o      (cfg),
    .sel_o      (sel),
    .ctrl0_wr_o (ctrl0_wr)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_ctr
    logic ev_w;
    if (i == 0) begin : g_cyc
      assign ev_w = 1'b1;
    end else if (i == 1) begin : g_ins
      assign ev_w = inst_ret_i;
    end else begin : g_prog
      assign ev_w = event_i[sel[i-2]];
    end
    assign inc_w[i]  = cfg.cnt_en[i] & ev_w & (kernel_i ? cfg.krn_en[i] : cfg.usr_en[i]);
    assign cnt_wr[i] = reg_we_i && (reg_addr_i == ADDR_W'(CNT_BASE + i));

    pmc_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cnt_wr[i]),
      .wdata_i (reg_wdata_i[CNT_W-1:0]),
      .inc_i   (inc_w[i]),
      .val_o   (cnt_val[i]),
      .trip_o  (trip_w[i])
    );
  end

  pmc_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trip_i     (trip_w),
    .irq_en_i   (cfg.irq_en),
    .stat_wr_i  (reg_we_i && (reg_addr_i == A_STAT)),
    .stat_clr_i (reg_wdata_i[NUM_CNT-1:0]),
    .ctrl0_wr_i (ctrl0_wr),
    .mode_i     (cfg.mode),
    .status_o   (status),
    .active_o   (active),
    .irq_o      (irq_o)
  );

  logic [DATA_W-1:0] ctrl0_img, ctrl1_img, sel0_img, sel1_img;

  always_comb begin
    ctrl0_img = '0;
    ctrl0_img[LO_A+:8] = cfg.cnt_en[7:0];
    ctrl0_img[LO_B+:8] = cfg.irq_en[7:0];
    ctrl0_img[HI_A+:2] = cfg.cnt_en[9:8];
    ctrl0_img[HI_B+:2] = cfg.irq_en[9:8];
    ctrl0_img[MODE_B]  = cfg.mode;
    ctrl0_img[ACT_B]   = active;
    ctrl1_img = '0;
    ctrl1_img[LO_A+:8] = cfg.usr_en[7:0];
    ctrl1_img[LO_B+:8] = cfg.krn_en[7:0];
    ctrl1_img[HI_A+:2] = cfg.usr_en[9:8];
    ctrl1_img[HI_B+:2] = cfg.krn_en[9:8];
    sel0_img = '0;
    sel1_img = '0;
    for (int j = 0; j < PER_WORD; j++) begin
      sel0_img[j*SEL_W+:SEL_W] = sel[j];
      sel1_img[j*SEL_W+:SEL_W] = sel[j+PER_WORD];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CTRL0)      reg_rdata_o = ctrl0_img;
    else if (reg_addr_i == A_CTRL1) reg_rdata_o = ctrl1_img;
    else if (reg_addr_i == A_SEL0)  reg_rdata_o = sel0_img;
    else if (reg_addr_i == A_SEL1)  reg_rdata_o = sel1_img;
    else if (reg_addr_i == A_STAT)  reg_rdata_o = DATA_W'(status);
    for (int i = 0; i < NUM_CNT; i++)
      if (reg_addr_i == ADDR_W'(CNT_BASE + i)) reg_rdata_o = DATA_W'(cnt_val[i]);
  end

  assert_irq_needs_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode == IMODE_OFF) |-> !irq_o);
endmodule

// File: tb/pmc_bank_bench.sv
module pmc_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [4:0]   addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic [255:0] ev = '0;
  logic         inst = 1'b0;
  logic         kern = 1'b0;
  logic         irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit          is_irq;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_bank u_pmc_bank (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .event_i(ev),
    .inst_ret_i(inst), .kernel_i(kern), .irq_o(irq)
  );

  // monitor: compare queued expectations against outputs
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = sb.pop_front();
      act = it.is_irq ? 64'(irq) : rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [63:0] mk_ctrl(logic [9:0] a, logic [9:0] b, logic m);
    logic [63:0] v = '0;
    v[7:0] = a[7:0]; v[15:8] = b[7:0]; v[17:16] = a[9:8]; v[19:18] = b[9:8];
    v[20] = m;
    return v;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(posedge clk); #1 we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [63:0] e, input string tag);
    item_t it;
    @(posedge clk); #1 addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = 64'(e); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pulse(input int idx, input int n, input logic k);
    @(posedge clk); #1 ev[idx] = 1'b1; kern = k;
    repeat (n) @(posedge clk);
    #1 ev[idx] = 1'b0; kern = 1'b0;
  endtask

  task automatic pulse_inst(input int n);
    @(posedge clk); #1 inst = 1'b1;
    repeat (n) @(posedge clk);
    #1 inst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] c0;
    logic [63:0] tp;
    tp = 64'(1) << (CW-1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(5'd0, 64'h0, "R1 ctrl0 after reset");
    rd(5'd1, 64'h0, "R1 ctrl1 after reset");
    rd(5'd11, 64'h0, "R1 counter3 after reset");
    rd(5'd4, 64'h0, "R1 status after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R4 select words
    wr(5'd2, 64'h4030_2010);
    wr(5'd3, 64'hAAAA_5550);
    rd(5'd3, 64'hAAAA_5550, "R4 sel1 readback");
    // R5 qualifiers: c0 kernel only, c7 kernel only, c1 user only
    wr(5'd1, mk_ctrl(10'b11_0111_1110, 10'b11_1111_1101, 1'b0));
    rd(5'd1, mk_ctrl(10'b11_0111_1110, 10'b11_1111_1101, 1'b0), "R5 ctrl1 readback");
    c0 = mk_ctrl(10'b10_1111_1111, 10'b00_0001_0000, 1'b1);
    wr(5'd0, c0);
    rd(5'd0, c0, "R5 ctrl0 readback");

    // R2/R4 event routing
    pulse(8'h10, 5, 1'b0);
    rd(5'd10, 64'd5, "R2 counter2 counts its event");
    rd(5'd11, 64'd0, "R4 counter3 ignores other code");
    // R2 privilege
    pulse(8'h55, 4, 1'b0);
    rd(5'd15, 64'd0, "R2 counter7 blocked in user");
    pulse(8'h55, 3, 1'b1);
    rd(5'd15, 64'd3, "R2 counter7 counts in kernel");
    rd(5'd8, 64'd3, "R3 counter0 counts kernel cycles");
    // R5 high enable group
    pulse(8'hAA, 4, 1'b0);
    rd(5'd17, 64'd4, "R5 counter9 enabled in high group");
    rd(5'd16, 64'd0, "R5 counter8 disabled");
    // R3 instructions
    pulse_inst(6);
    rd(5'd9, 64'd6, "R3 counter1 counts instructions");

    // R7 write beats increment
    @(posedge clk); #1 we = 1'b1; addr = 5'd10; wdata = 64'd100; ev[8'h10] = 1'b1;
    @(posedge clk); #1 we = 1'b0; ev[8'h10] = 1'b0;
    rd(5'd10, 64'd100, "R7 write wins over event");

    // R6 width and wrap
    wr(5'd14, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(5'd14, 64'h0000_FFFF_FFFF_FFFF, "R6 upper write bits dropped");
    pulse(8'h50, 1, 1'b0);
    rd(5'd14, 64'd0, "R6 wrap to zero");
    rd(5'd4, 64'd0, "R8 wrap sets no status");

    // R8/R9 trigger crossing
    wr(5'd12, tp - 64'd1);
    pulse(8'h30, 1, 1'b0);
    rd(5'd12, tp, "R6 counter4 reaches trigger");
    rd(5'd4, 64'h10, "R8 status bit4 set");
    chk_irq(1'b1, "R9 irq raised");
    rd(5'd0, c0 | (64'(1) << 21), "R9 active flag visible");
    wr(5'd13, tp - 64'd1);
    pulse(8'h40, 1, 1'b0);
    rd(5'd4, 64'h10, "R8 no status without irq enable");
    wr(5'd0, c0);
    chk_irq(1'b0, "R9 ctrl0 write drops active");
    rd(5'd4, 64'h10, "R8 status kept after ctrl0 write");
    wr(5'd4, 64'h10);
    rd(5'd4, 64'h0, "R8 write-one clears status");

    wr(5'd12, tp - 64'd1);
    pulse(8'h30, 1, 1'b0);
    chk_irq(1'b1, "R9 irq raised again");
    wr(5'd0, mk_ctrl(10'b10_1111_1111, 10'b00_0001_0000, 1'b0));
    chk_irq(1'b0, "R9 mode off masks irq");
    wr(5'd0, c0);
    chk_irq(1'b0, "R9 fast mode with active cleared");

    wait (sb.size() == 0);
    @(negedge clk); #1;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule